// File: doc/BRIEF.md
# Overriding Two-Level Branch Direction Predictor

This block gives the fetch stage a branch direction at once and corrects it a few cycles later. Each request carries a branch address and a tag. In the same cycle a small global-history-hashed table of 2-bit saturating counters answers with a fast direction, and fetch continues down that path. The request also enters a slower, more accurate second level: a table of perceptrons indexed by low address bits, whose weighted vote over a long global history is computed in the request cycle and held in a delay line that models the slow predictor's access time.

When the delayed result leaves the delay line, the block presents it together with the tag of the request it belongs to. If its direction differs from the fast direction issued for that same request, an override strobe is raised for that one cycle, and fetch must redirect to the slow direction. The slow answer always wins. Resolved branches train both levels and shift the outcome into the global history.

Top module: `ovr_bpred`

## Requirements
- R1: `fast_taken_o` is combinational in the request cycle and equals bit 1 of the 2-bit counter at index `pc[IDX_W-1:0] XOR ghist[IDX_W-1:0]`. Every counter resets to 1 (weakly not taken), so `fast_taken_o` is 0 after reset.
- R2: On a resolution the counter at that index moves one step toward the outcome (up on taken, down on not taken) and saturates at 0 and 3.
- R3: The global history resets to all zeros. Each resolution shifts the resolved outcome into bit 0, and the older bits move up by one place. Requests do not change it.
- R4: A request made in cycle c produces `slow_valid_o` high in cycle c+SLOW_LAT and in no other cycle, with `slow_tag_o` equal to that request's tag. SLOW_LAT is between 2 and 4.
- R5: The slow direction is computed from the state in the request cycle. Row `pc[ROW_W-1:0]` is used. The sum starts from the bias weight, and for each history bit i the weight i+1 is added if the bit is 1 and subtracted if it is 0. Taken means sum >= 0. Weights reset to 0.
- R6: On a resolution the perceptron row is trained only if its sign disagrees with the outcome or |sum| <= THETA, with THETA = floor(1.93*HIST_W)+14. Training moves the bias toward the outcome and moves each weight +1 when its history bit equals the outcome (-1 otherwise). Weights saturate at ±(2^(WGT_W-1)-1).
- R7: `override_o` is high only while `slow_valid_o` is high, and exactly when `slow_taken_o` differs from the `fast_taken_o` issued for that request.
- R8: Requests in consecutive cycles each get their own slow result, in request order, one per cycle.
- R9: When a request and a resolution happen in the same cycle, both predictions for the request use the state from before that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Prediction request this cycle |
| req_pc_i | input | PC_W | Branch address of the request |
| req_tag_i | input | TAG_W | Tag returned with the slow result |
| fast_taken_o | output | 1 | First-level direction, same cycle |
| slow_valid_o | output | 1 | Second-level result present |
| slow_taken_o | output | 1 | Second-level direction |
| slow_tag_o | output | TAG_W | Tag of the request the slow result belongs to |
| override_o | output | 1 | Redirect fetch to the slow direction |
| res_valid_i | input | 1 | Resolved branch this cycle |
| res_pc_i | input | PC_W | Branch address of the resolved branch |
| res_taken_i | input | 1 | Resolved outcome |

## Verification
The bound checker runs on every cycle. It checks that each slow result shows up exactly SLOW_LAT cycles after its request and carries that request's tag. It checks that an override happens only with a slow result, and only when the slow direction differs from the fast direction seen at the ports for that request. It also checks that the fast answer cannot change for a repeated address unless a resolution came in between. The learning behaviour needs the bench's scenarios: counter saturation, history shifting, the perceptron's threshold-gated and saturating training, and the ordering when a request and a resolution share a cycle. For these the bench compares each direction against a model driven by its own counter, weight and history arithmetic.

// File: rtl/bp_pkg.sv
// Package shared by the overriding predictor: 2-bit counter type and its
// saturating step. Assumes nothing beyond two-state synthesizable logic.
package bp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_RESET = 2'b01;

    // Move a counter one step toward the outcome, holding at 0 and 3.
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        if (up) begin
            return (c == 2'b11) ? c : c + 2'b01;
        end
        return (c == 2'b00) ? c : c - 2'b01;
    endfunction

endpackage

// File: rtl/bp_gshare.sv
// First-level predictor: a table of 2-bit counters indexed by address XOR
// global history. Read is combinational; training writes on the clock.
// Assumes the caller passes already-sliced address and history bits.
module bp_gshare
    import bp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_pc,
    input  logic [IDX_W-1:0] hist,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_pc,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t            tbl [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    // Hash both ports with the current history.
    always_comb begin
        rd_idx   = rd_pc ^ hist;
        wr_idx   = wr_pc ^ hist;
        rd_taken = tbl[rd_idx][1];
    end

    // Reset all counters to weakly not taken; step one on each resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= CTR_RESET;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
        end
    end

endmodule

// File: rtl/bp_perceptron.sv
// Second-level predictor core: a table of perceptrons, one row per address
// slice, each with a bias and one weight per history bit. Prediction is a
// combinational signed vote. The caller adds the latency. Training is
// gated by sign error or a small margin, and weights saturate symmetrically.
module bp_perceptron #(
    parameter int ROW_W  = 3,
    parameter int HIST_W = 23,
    parameter int WGT_W  = 8,
    parameter int THETA  = 58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] hist,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              rd_taken,
    input  logic              tr_en,
    input  logic [ROW_W-1:0]  tr_row,
    input  logic              tr_taken
);
    localparam int ROWS  = 1 << ROW_W;
    localparam int NW    = HIST_W + 1;
    localparam int SUM_W = WGT_W + $clog2(NW) + 1;

    typedef logic signed [WGT_W-1:0] wgt_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    localparam wgt_t WMAX    = wgt_t'((1 << (WGT_W - 1)) - 1);
    localparam wgt_t WMIN    = -WMAX;
    localparam sum_t THETA_S = sum_t'(THETA);

    wgt_t wt [ROWS][NW];
    sum_t rd_sum;
    sum_t tr_sum;
    sum_t tr_mag;
    logic tr_dir;
    logic tr_need;

    // Sign-extend one weight to the sum width.
    function automatic sum_t sx(input wgt_t w);
        return sum_t'(w);
    endfunction

    // Step one weight toward agreement, holding at the symmetric limits.
    function automatic wgt_t wstep(input wgt_t w, input logic up);
        if (up) begin
            return (w == WMAX) ? w : w + wgt_t'(1);
        end
        return (w == WMIN) ? w : w - wgt_t'(1);
    endfunction

    // Vote of the requested row over the current history.
    always_comb begin
        rd_sum = sx(wt[rd_row][0]);
        for (int i = 0; i < HIST_W; i++) begin
            if (hist[i]) rd_sum = rd_sum + sx(wt[rd_row][i+1]);
            else         rd_sum = rd_sum - sx(wt[rd_row][i+1]);
        end
        rd_taken = !rd_sum[SUM_W-1];
    end

    // Vote of the resolved row and the decision whether to train it.
    always_comb begin
        tr_sum = sx(wt[tr_row][0]);
        for (int i = 0; i < HIST_W; i++) begin
            if (hist[i]) tr_sum = tr_sum + sx(wt[tr_row][i+1]);
            else         tr_sum = tr_sum - sx(wt[tr_row][i+1]);
        end
        tr_dir  = !tr_sum[SUM_W-1];
        tr_mag  = tr_sum[SUM_W-1] ? -tr_sum : tr_sum;
        tr_need = (tr_dir != tr_taken) || (tr_mag <= THETA_S);
    end

    // Clear all weights on reset; apply one training step when needed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int j = 0; j < NW; j++) begin
                    wt[r][j] <= '0;
                end
            end
        end else if (tr_en && tr_need) begin
            wt[tr_row][0] <= wstep(wt[tr_row][0], tr_taken);
            for (int j = 0; j < HIST_W; j++) begin
                wt[tr_row][j+1] <= wstep(wt[tr_row][j+1], tr_taken == hist[j]);
            end
        end
    end

endmodule

// File: rtl/bp_delay_pipe.sv
// Fixed-length delay line that stands in for the slow predictor's access
// time. It carries a valid bit and a payload through LAT stages, so an
// entry loaded in cycle c is presented in cycle c+LAT. Assumes LAT >= 1.
module bp_delay_pipe #(
    parameter int W   = 6,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    for (genvar g = 0; g < LAT; g++) begin : g_stage
        logic         v;
        logic [W-1:0] d;
        if (g == 0) begin : g_head
            // First stage captures the incoming request.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v <= 1'b0;
                    d <= '0;
                end else begin
                    v <= in_valid;
                    d <= in_data;
                end
            end
        end else begin : g_body
            // Later stages copy the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v <= 1'b0;
                    d <= '0;
                end else begin
                    v <= g_stage[g-1].v;
                    d <= g_stage[g-1].d;
                end
            end
        end
    end

    assign out_valid = g_stage[LAT-1].v;
    assign out_data  = g_stage[LAT-1].d;

endmodule

// File: rtl/ovr_bpred.sv
// Overriding two-level branch direction predictor. The fast counter table
// answers in the request cycle; the perceptron vote, taken from the same
// cycle's state, is delayed by SLOW_LAT cycles together with the tag and
// the fast direction. The block flags an override when they disagree. A
// resolution trains both levels and then shifts the outcome into the
// global history.
// Assumes: 2 <= SLOW_LAT <= 4, ROW_W <= IDX_W < PC_W, IDX_W <= HIST_W.
module ovr_bpred #(
    parameter int PC_W     = 16,
    parameter int IDX_W    = 6,
    parameter int ROW_W    = 3,
    parameter int HIST_W   = 23,
    parameter int WGT_W    = 8,
    parameter int SLOW_LAT = 3,
    parameter int TAG_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [PC_W-1:0]  req_pc_i,
    input  logic [TAG_W-1:0] req_tag_i,
    output logic             fast_taken_o,
    output logic             slow_valid_o,
    output logic             slow_taken_o,
    output logic [TAG_W-1:0] slow_tag_o,
    output logic             override_o,
    input  logic             res_valid_i,
    input  logic [PC_W-1:0]  res_pc_i,
    input  logic             res_taken_i
);
    localparam int THETA  = (193 * HIST_W) / 100 + 14;
    localparam int PIPE_W = TAG_W + 2;

    logic [HIST_W-1:0] ghist;
    logic              slow_now;
    logic [PIPE_W-1:0] pipe_in;
    logic [PIPE_W-1:0] pipe_out;
    logic              pipe_out_v;
    logic              rec_fast;
    logic              unused_pc_hi;

    assign unused_pc_hi = ^{req_pc_i[PC_W-1:IDX_W], res_pc_i[PC_W-1:IDX_W]};

    // Global history: shift in each resolved outcome at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ghist <= '0;
        end else if (res_valid_i) begin
            ghist <= {ghist[HIST_W-2:0], res_taken_i};
        end
    end

    bp_gshare #(
        .IDX_W (IDX_W)
    ) i_fast (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc    (req_pc_i[IDX_W-1:0]),
        .hist     (ghist[IDX_W-1:0]),
        .rd_taken (fast_taken_o),
        .wr_en    (res_valid_i),
        .wr_pc    (res_pc_i[IDX_W-1:0]),
        .wr_taken (res_taken_i)
    );

    bp_perceptron #(
        .ROW_W  (ROW_W),
        .HIST_W (HIST_W),
        .WGT_W  (WGT_W),
        .THETA  (THETA)
    ) i_slow (
        .clk      (clk),
        .rst_n    (rst_n),
        .hist     (ghist),
        .rd_row   (req_pc_i[ROW_W-1:0]),
        .rd_taken (slow_now),
        .tr_en    (res_valid_i),
        .tr_row   (res_pc_i[ROW_W-1:0]),
        .tr_taken (res_taken_i)
    );

    // Payload carried to the compare point: tag, fast and slow directions.
    assign pipe_in = {req_tag_i, fast_taken_o, slow_now};

    bp_delay_pipe #(
        .W   (PIPE_W),
        .LAT (SLOW_LAT)
    ) i_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid_i),
        .in_data   (pipe_in),
        .out_valid (pipe_out_v),
        .out_data  (pipe_out)
    );

    // Present the slow result and flag disagreement with the recorded fast one.
    always_comb begin
        slow_valid_o = pipe_out_v;
        slow_tag_o   = pipe_out[PIPE_W-1:2];
        rec_fast     = pipe_out[1];
        slow_taken_o = pipe_out[0];
        override_o   = pipe_out_v && (rec_fast != pipe_out[0]);
    end

endmodule

// File: rtl/bp_checker.sv
// Cycle-by-cycle properties of the overriding predictor, observed at its
// ports. A shadow shift line records each request's valid, tag and fast
// direction so that the delayed result can be matched to its request.
module bp_checker #(
    parameter int PC_W  = 16,
    parameter int TAG_W = 4,
    parameter int LAT   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic [PC_W-1:0]  req_pc_i,
    input logic [TAG_W-1:0] req_tag_i,
    input logic             fast_taken_o,
    input logic             slow_valid_o,
    input logic             slow_taken_o,
    input logic [TAG_W-1:0] slow_tag_o,
    input logic             override_o,
    input logic             res_valid_i
);
    logic             sh_v    [LAT];
    logic [TAG_W-1:0] sh_tag  [LAT];
    logic             sh_fast [LAT];
    logic             armed;

    // Shadow record of port values at request time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            for (int i = 0; i < LAT; i++) begin
                sh_v[i]    <= 1'b0;
                sh_tag[i]  <= '0;
                sh_fast[i] <= 1'b0;
            end
        end else begin
            armed      <= 1'b1;
            sh_v[0]    <= req_valid_i;
            sh_tag[0]  <= req_tag_i;
            sh_fast[0] <= fast_taken_o;
            for (int i = 1; i < LAT; i++) begin
                sh_v[i]    <= sh_v[i-1];
                sh_tag[i]  <= sh_tag[i-1];
                sh_fast[i] <= sh_fast[i-1];
            end
        end
    end

    a_r4_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (slow_valid_o == sh_v[LAT-1]));

    a_r4_tag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        slow_valid_o |-> (slow_tag_o == sh_tag[LAT-1]));

    a_r7_override_on_disagree: assert property (@(posedge clk) disable iff (!rst_n)
        slow_valid_o |-> (override_o == (slow_taken_o != sh_fast[LAT-1])));

    a_r7_no_stray_override: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_valid_o |-> !override_o);

    a_r1_fast_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && req_valid_i && $past(req_valid_i) && (req_pc_i == $past(req_pc_i))
         && !$past(res_valid_i)) |-> (fast_taken_o == $past(fast_taken_o)));

endmodule

bind ovr_bpred bp_checker #(
    .PC_W  (PC_W),
    .TAG_W (TAG_W),
    .LAT   (SLOW_LAT)
) i_bp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_pc_i     (req_pc_i),
    .req_tag_i    (req_tag_i),
    .fast_taken_o (fast_taken_o),
    .slow_valid_o (slow_valid_o),
    .slow_taken_o (slow_taken_o),
    .slow_tag_o   (slow_tag_o),
    .override_o   (override_o),
    .res_valid_i  (res_valid_i)
);

// File: tb/test_ovr_bpred.sv
// Bench for the overriding predictor at its default configuration. It
// keeps its own arithmetic model of counters, weights and history, and
// drives slot sequences in which each cycle may carry a request, a
// resolution, or both.
module test_ovr_bpred;
    localparam int PC_W  = 16;
    localparam int TAG_W = 4;
    localparam int LAT   = 3;
    localparam int NSLOT = 80;
    localparam int THETA = 58;
    localparam int WLIM  = 127;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid_i = 1'b0;
    logic [PC_W-1:0]  req_pc_i = '0;
    logic [TAG_W-1:0] req_tag_i = '0;
    logic             fast_taken_o;
    logic             slow_valid_o;
    logic             slow_taken_o;
    logic [TAG_W-1:0] slow_tag_o;
    logic             override_o;
    logic             res_valid_i = 1'b0;
    logic [PC_W-1:0]  res_pc_i = '0;
    logic             res_taken_i = 1'b0;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    ovr_bpred i_ovr_bpred (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_pc_i     (req_pc_i),
        .req_tag_i    (req_tag_i),
        .fast_taken_o (fast_taken_o),
        .slow_valid_o (slow_valid_o),
        .slow_taken_o (slow_taken_o),
        .slow_tag_o   (slow_tag_o),
        .override_o   (override_o),
        .res_valid_i  (res_valid_i),
        .res_pc_i     (res_pc_i),
        .res_taken_i  (res_taken_i)
    );

    always #4 clk = ~clk;

    // Reference model state.
    logic [1:0]  m_ctr [64];
    int          m_w   [8][24];
    logic [22:0] m_gh;

    // Slot program and the expectations recorded for it.
    logic             q_req [NSLOT];
    logic [PC_W-1:0]  q_pc  [NSLOT];
    logic             q_res [NSLOT];
    logic [PC_W-1:0]  q_rpc [NSLOT];
    logic             q_rt  [NSLOT];
    logic             e_fast [NSLOT];
    logic             e_slow [NSLOT];

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_idx(input logic [PC_W-1:0] pc);
        return int'(pc[5:0] ^ m_gh[5:0]);
    endfunction

    function automatic int m_y(input logic [PC_W-1:0] pc);
        int r = int'(pc[2:0]);
        int y = m_w[r][0];
        for (int i = 0; i < 23; i++) begin
            if (m_gh[i]) y += m_w[r][i+1];
            else         y -= m_w[r][i+1];
        end
        return y;
    endfunction

    function automatic int wclamp(input int w);
        if (w > WLIM)  return WLIM;
        if (w < -WLIM) return -WLIM;
        return w;
    endfunction

    // R2 R3 R6: model update on one resolution.
    task automatic m_train(input logic [PC_W-1:0] pc, input logic t);
        int k = m_idx(pc);
        int y = m_y(pc);
        int r = int'(pc[2:0]);
        int mag = (y < 0) ? -y : y;
        logic dir = (y >= 0);
        if (t && m_ctr[k] != 2'd3) m_ctr[k] = m_ctr[k] + 2'd1;
        if (!t && m_ctr[k] != 2'd0) m_ctr[k] = m_ctr[k] - 2'd1;
        if (dir != t || mag <= THETA) begin
            m_w[r][0] = wclamp(m_w[r][0] + (t ? 1 : -1));
            for (int i = 0; i < 23; i++) begin
                m_w[r][i+1] = wclamp(m_w[r][i+1] + ((t == m_gh[i]) ? 1 : -1));
            end
        end
        m_gh = {m_gh[21:0], t};
    endtask

    task automatic m_reset();
        for (int i = 0; i < 64; i++) m_ctr[i] = 2'd1;
        for (int r = 0; r < 8; r++) begin
            for (int j = 0; j < 24; j++) m_w[r][j] = 0;
        end
        m_gh = '0;
    endtask

    task automatic clear_slots();
        for (int i = 0; i < NSLOT; i++) begin
            q_req[i] = 1'b0; q_pc[i] = '0; q_res[i] = 1'b0;
            q_rpc[i] = '0;   q_rt[i] = 1'b0;
            e_fast[i] = 1'b0; e_slow[i] = 1'b0;
        end
    endtask

    // Run n slots. At each falling edge the registered outputs are checked
    // first, then that slot's inputs are driven.
    task automatic run_slots(input int n);
        for (int m = 0; m < n + LAT + 1; m++) begin
            int src = m - LAT;
            bit exp_v;
            @(negedge clk);
            exp_v = (src >= 0) && (src < n) && q_req[src];
            chk("R4 slow_valid", int'(slow_valid_o), int'(exp_v));
            if (exp_v) begin
                chk("R4 slow_tag", int'(slow_tag_o), src % 16);
                chk("R5 slow_taken", int'(slow_taken_o), int'(e_slow[src]));
                chk("R7 override", int'(override_o), int'(e_slow[src] != e_fast[src]));
            end else begin
                chk("R7 override idle", int'(override_o), 0);
            end
            if (m < n) begin
                req_valid_i = q_req[m];
                req_pc_i    = q_pc[m];
                req_tag_i   = TAG_W'(m % 16);
                res_valid_i = q_res[m];
                res_pc_i    = q_rpc[m];
                res_taken_i = q_rt[m];
            end else begin
                req_valid_i = 1'b0;
                res_valid_i = 1'b0;
            end
            #1;
            if (m < n && q_req[m]) begin
                // R9: expectations come from the state before this slot's resolution.
                e_fast[m] = m_ctr[m_idx(q_pc[m])][1];
                e_slow[m] = (m_y(q_pc[m]) >= 0);
                chk("R1 fast_taken", int'(fast_taken_o), int'(e_fast[m]));
            end
            if (m < n && q_res[m]) m_train(q_rpc[m], q_rt[m]);
        end
    endtask

    int lfsr = 32'h1d87_2a95;
    function automatic int next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >>> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_reset();
        clear_slots();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: R1 weakly not taken, R4/R7 no result, no override.
        req_pc_i = 16'h0005;
        #1;
        chk("R1 reset fast", int'(fast_taken_o), 0);
        chk("R4 reset slow_valid", int'(slow_valid_o), 0);
        chk("R7 reset override", int'(override_o), 0);

        // R5 R7: untrained slow votes taken (sum 0), fast says not taken.
        clear_slots();
        q_req[0] = 1'b1; q_pc[0] = 16'h0005;
        run_slots(1);

        // R8: a burst of back-to-back requests over all first-level indices.
        clear_slots();
        for (int i = 0; i < 64; i++) begin
            q_req[i] = 1'b1; q_pc[i] = PC_W'(i * 37 + 16'h0400);
        end
        run_slots(64);

        // R2 R3: a long taken run on one address saturates its counter,
        // then one not-taken result must leave the reread index still taken.
        clear_slots();
        for (int i = 0; i < 10; i++) begin
            q_res[i] = 1'b1; q_rpc[i] = 16'h0123; q_rt[i] = 1'b1;
        end
        q_res[10] = 1'b1; q_rpc[10] = 16'h0123; q_rt[10] = 1'b0;
        q_req[11] = 1'b1; q_pc[11] = 16'h0122;
        q_req[12] = 1'b1; q_pc[12] = 16'h0123;
        run_slots(13);

        // R6: a history-correlated pattern lets the perceptron learn, with
        // each request resolved in the following slot.
        for (int it = 0; it < 300; it++) begin
            int rv = next_rand();
            logic [PC_W-1:0] pc = PC_W'(rv & 16'h03ff);
            logic t = ((it % 3) == 0) ^ m_gh[4] ^ logic'(rv[20] & rv[21] & rv[22]);
            clear_slots();
            q_req[0] = 1'b1; q_pc[0] = pc;
            q_res[1] = 1'b1; q_rpc[1] = pc; q_rt[1] = t;
            run_slots(2);
        end

        // R9: requests and resolutions sharing cycles in a dense stream.
        clear_slots();
        for (int i = 0; i < 60; i++) begin
            int rv = next_rand();
            q_req[i] = 1'b1; q_pc[i] = PC_W'(rv & 16'h00ff);
            q_res[i] = rv[9]; q_rpc[i] = PC_W'((rv >>> 10) & 16'h00ff); q_rt[i] = rv[24];
        end
        run_slots(60);

        // R3: after a known history of outcomes, a final sweep reads every index.
        clear_slots();
        for (int i = 0; i < 8; i++) begin
            q_res[i] = 1'b1; q_rpc[i] = PC_W'(i); q_rt[i] = logic'(i % 2);
        end
        for (int i = 8; i < 72; i++) begin
            q_req[i] = 1'b1; q_pc[i] = PC_W'(i - 8);
        end
        run_slots(72);

        finish_run();
    end

endmodule